// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block holds a calendar date as packed BCD fields: a two-digit day, a two-digit month and a four-digit year. Each qualified advance pulse moves the date forward by exactly one day. The pulse may come from the day-rollover output of a time-of-day counter or from a manual adjust input. The two sources are ORed together, so a cycle in which both are high still advances only one day.

The day field counts from 01 up to the length of the current month and is compared digit by digit against that length. At the end of the month the day returns to 01 and a one-cycle month carry is raised. The month counts 01 to 12. When it wraps back to 01 it raises a one-cycle year carry and bumps the year. The year is a chain of BCD digits with a ripple carry between them. A synchronous reset loads 1 January of a parameterised start year, which defaults to 2000. Display multiplexing and segment decoding are left to other blocks.

Top module: `bcd_calendar`

## Requirements
- R1: The day output is 8 bits: tens digit in bits 7:4, units digit in bits 3:0. Both are BCD, and the value always lies between 01 and the current month length.
- R2: Below the month length, when the units digit is not 9, an advance adds 1 to the units digit and leaves the tens digit unchanged.
- R3: Below the month length, when the units digit is 9, an advance adds 1 to the tens digit and clears the units digit to 0 (for example 09 becomes 10).
- R4: When the day equals the month length, an advance sets the day to 01 and raises the month carry output for exactly one cycle, in the same cycle the new day appears. The month advances in that cycle too.
- R5: An advance is the OR of the adjust and day-rollover inputs. With neither input high, day, month and year hold and both carries stay low. With both inputs high in one cycle, the date moves by a single day.
- R6: Months 01, 03, 05, 07, 08, 10 and 12 last 31 days. Months 04, 06, 09 and 11 last 30 days.
- R7: February lasts 29 days when the two low year digits form a multiple of 4, and 28 days otherwise.
- R8: The month is BCD, tens digit in bits 7:4, in the range 01 to 12. After 12 it returns to 01, the year increments, and the year carry output goes high for exactly that one cycle.
- R9: The year is four BCD digits, the most significant in bits 15:12. Each digit carries into the next when it passes 9, and 9999 is followed by 0000.
- R10: While reset is high, the next clock loads day 01, month 01 and the start year (default 2000), and clears both carry outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adj_pulse | input | 1 | Manual adjust, one-cycle advance request |
| tod_day_carry | input | 1 | Day rollover from the time-of-day counter |
| day_o | output | 8 | Day, two BCD digits |
| month_o | output | 8 | Month, two BCD digits |
| year_o | output | 16 | Year, four BCD digits |
| month_carry_o | output | 1 | One-cycle pulse when the day wraps to 01 |
| year_carry_o | output | 1 | One-cycle pulse when the month wraps to 01 |

## Verification
The assertions watch on every cycle that the day and month stay legal BCD values within their ranges. They also check that the date holds when no advance arrives, that each carry lasts one cycle and coincides with its field returning to 01, and that reset loads the start date. Only the bench scenarios can show the actual month lengths, the February leap rule, the digit-by-digit increments of the day, and the full-width year ripple through 9999 to 0000. The bench does this by walking the date past month, year and century boundaries and comparing against an integer calendar.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int DIGIT_W = 4;
    localparam int FIELD_W = 2 * DIGIT_W;

    typedef logic [FIELD_W-1:0] bcd2_t;

    // Leap test on the two low year digits: (10t+u) mod 4 == (2t+u) mod 4
    function automatic logic year_is_leap(input bcd2_t yy);
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
        tens  = yy[FIELD_W-1:DIGIT_W];
        units = yy[DIGIT_W-1:0];
        if (tens[0] == 1'b0)
            return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
        else
            return (units == 4'd2) || (units == 4'd6);
    endfunction

    function automatic bcd2_t days_in_month(input bcd2_t mon, input logic leap);
        bcd2_t len;
        unique case (mon)
            8'h02:                      len = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: len = 8'h30;
            default:                    len = 8'h31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/cal_day_ctr.sv
module cal_day_ctr
    import cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv_i,
    input  bcd2_t len_i,
    output bcd2_t day_o,
    output logic  wrap_o
);

    localparam logic [DIGIT_W-1:0] MAX_DIGIT = 4'd9;

    bcd2_t              day_q;
    bcd2_t              day_d;
    logic [DIGIT_W-1:0] tens;
    logic [DIGIT_W-1:0] units;

    assign tens   = day_q[FIELD_W-1:DIGIT_W];
    assign units  = day_q[DIGIT_W-1:0];
    assign wrap_o = adv_i && (day_q == len_i);

    always_comb begin
        day_d = day_q;
        if (adv_i) begin
            if (day_q == len_i)
                day_d = 8'h01;
            else if (units == MAX_DIGIT)
                day_d = {tens + 4'd1, 4'd0};
            else
                day_d = {tens, units + 4'd1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) day_q <= 8'h01;
        else     day_q <= day_d;
    end

    assign day_o = day_q;

endmodule

// File: rtl/cal_month_ctr.sv
module cal_month_ctr
    import cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  inc_i,
    output bcd2_t month_o,
    output logic  wrap_o
);

    localparam bcd2_t LAST_MONTH = 8'h12;

    bcd2_t mon_q;
    bcd2_t mon_d;

    assign wrap_o = inc_i && (mon_q == LAST_MONTH);

    always_comb begin
        mon_d = mon_q;
        if (inc_i) begin
            if (mon_q == LAST_MONTH)
                mon_d = 8'h01;
            else if (mon_q[DIGIT_W-1:0] == 4'd9)
                mon_d = 8'h10;
            else
                mon_d = {mon_q[FIELD_W-1:DIGIT_W], mon_q[DIGIT_W-1:0] + 4'd1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mon_q <= 8'h01;
        else     mon_q <= mon_d;
    end

    assign month_o = mon_q;

endmodule

// File: rtl/cal_year_ctr.sv
module cal_year_ctr
    import cal_pkg::*;
#(
    parameter int                          DIGITS    = 4,
    parameter logic [DIGITS*DIGIT_W-1:0]   INIT_YEAR = 'h2000
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        inc_i,
    output logic [DIGITS*DIGIT_W-1:0]   year_o
);

    logic [DIGITS:0] carry;

    assign carry[0] = inc_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [DIGIT_W-1:0] dig_q;
        logic               at_nine;

        assign at_nine      = (dig_q == 4'd9);
        assign carry[g+1]   = carry[g] && at_nine;

        always_ff @(posedge clk) begin
            if (rst)
                dig_q <= INIT_YEAR[g*DIGIT_W +: DIGIT_W];
            else if (carry[g])
                dig_q <= at_nine ? 4'd0 : dig_q + 4'd1;
        end

        assign year_o[g*DIGIT_W +: DIGIT_W] = dig_q;
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int                              YEAR_DIGITS = 4,
    parameter logic [YEAR_DIGITS*4-1:0]        INIT_YEAR   = 'h2000
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         adj_pulse,
    input  logic                         tod_day_carry,
    output logic [7:0]                   day_o,
    output logic [7:0]                   month_o,
    output logic [YEAR_DIGITS*4-1:0]     year_o,
    output logic                         month_carry_o,
    output logic                         year_carry_o
);

    localparam int YEAR_W = YEAR_DIGITS * DIGIT_W;

    logic        adv;
    logic        day_wrap;
    logic        month_wrap;
    bcd2_t       month_len;
    bcd2_t       day_q;
    bcd2_t       month_q;
    logic [YEAR_W-1:0] year_q;

    assign adv       = adj_pulse | tod_day_carry;
    assign month_len = days_in_month(month_q, year_is_leap(year_q[FIELD_W-1:0]));

    cal_day_ctr u_day (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (adv),
        .len_i  (month_len),
        .day_o  (day_q),
        .wrap_o (day_wrap)
    );

    cal_month_ctr u_month (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (day_wrap),
        .month_o (month_q),
        .wrap_o  (month_wrap)
    );

    cal_year_ctr #(
        .DIGITS    (YEAR_DIGITS),
        .INIT_YEAR (INIT_YEAR)
    ) u_year (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (month_wrap),
        .year_o (year_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            month_carry_o <= 1'b0;
            year_carry_o  <= 1'b0;
        end else begin
            month_carry_o <= day_wrap;
            year_carry_o  <= month_wrap;
        end
    end

    assign day_o   = day_q;
    assign month_o = month_q;
    assign year_o  = year_q;

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk #(
    parameter int                       YEAR_DIGITS = 4,
    parameter logic [YEAR_DIGITS*4-1:0] INIT_YEAR   = 'h2000
)(
    input logic                     clk,
    input logic                     rst,
    input logic                     adj_pulse,
    input logic                     tod_day_carry,
    input logic [7:0]               day_o,
    input logic [7:0]               month_o,
    input logic [YEAR_DIGITS*4-1:0] year_o,
    input logic                     month_carry_o,
    input logic                     year_carry_o
);

    logic adv;
    assign adv = adj_pulse | tod_day_carry;

    // R1: day digits legal and day in 01..31
    p_day_bcd_r1: assert property (@(posedge clk) disable iff (rst)
        (day_o[3:0] <= 4'd9) && (day_o[7:4] <= 4'd3) && (day_o != 8'h00) && (day_o <= 8'h31));

    // R8: month legal
    p_month_range_r8: assert property (@(posedge clk) disable iff (rst)
        (month_o >= 8'h01) && (month_o <= 8'h12) && (month_o[3:0] <= 4'd9));

    // R5: no advance, no change
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(day_o) && $stable(month_o) && $stable(year_o)
                  && !month_carry_o && !year_carry_o));

    // R4: month carry lands with day 01 and lasts one cycle
    p_wrap_day_r4: assert property (@(posedge clk) disable iff (rst)
        month_carry_o |-> (day_o == 8'h01));
    p_carry_once_r4: assert property (@(posedge clk) disable iff (rst)
        month_carry_o |=> !month_carry_o);

    // R8: year carry lands with month 01 on the first day
    p_year_carry_r8: assert property (@(posedge clk) disable iff (rst)
        year_carry_o |-> (month_o == 8'h01 && month_carry_o));

    // R10: reset loads the start date
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (day_o == 8'h01 && month_o == 8'h01 && year_o == INIT_YEAR
                 && !month_carry_o && !year_carry_o));

endmodule

bind bcd_calendar bcd_calendar_chk #(
    .YEAR_DIGITS (YEAR_DIGITS),
    .INIT_YEAR   (INIT_YEAR)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .adj_pulse     (adj_pulse),
    .tod_day_carry (tod_day_carry),
    .day_o         (day_o),
    .month_o       (month_o),
    .year_o        (year_o),
    .month_carry_o (month_carry_o),
    .year_carry_o  (year_carry_o)
);

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/1ps
module bcd_calendar_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adj = 1'b0;
    logic        tod = 1'b0;
    logic        adj_w = 1'b0;
    logic        zero = 1'b0;
    logic [7:0]  day_o, month_o, day_w, month_w;
    logic [15:0] year_o, year_w;
    logic        mc, yc, mc_w, yc_w;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // integer calendar models
    int md = 1, mm = 1, my = 2000;
    int wd = 1, wm = 1, wy = 9998;

    always #5 clk = ~clk;

    bcd_calendar u_dut (
        .clk(clk), .rst(rst), .adj_pulse(adj), .tod_day_carry(tod),
        .day_o(day_o), .month_o(month_o), .year_o(year_o),
        .month_carry_o(mc), .year_carry_o(yc)
    );

    bcd_calendar #(.YEAR_DIGITS(4), .INIT_YEAR(16'h9998)) u_dut_wrap (
        .clk(clk), .rst(rst), .adj_pulse(adj_w), .tod_day_carry(zero),
        .day_o(day_w), .month_o(month_w), .year_o(year_w),
        .month_carry_o(mc_w), .year_carry_o(yc_w)
    );

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] b2(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [15:0] b4(input int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // advance the main instance by one day and compare against the model
    task automatic adv_main(input logic a, input logic t, input string tag);
        bit emc = 0, eyc = 0;
        md++;
        if (md > mlen(mm, my)) begin
            md = 1; emc = 1; mm++;
            if (mm > 12) begin mm = 1; eyc = 1; my = (my + 1) % 10000; end
        end
        @(negedge clk); adj = a; tod = t;
        @(negedge clk); adj = 1'b0; tod = 1'b0;
        chk(day_o == b2(md),   tag, "day",   {8'h0, day_o},   {8'h0, b2(md)});
        chk(month_o == b2(mm), tag, "month", {8'h0, month_o}, {8'h0, b2(mm)});
        chk(year_o == b4(my),  tag, "year",  year_o, b4(my));
        chk(mc == emc, "R4", "month carry", {15'h0, mc}, {15'h0, emc});
        chk(yc == eyc, "R8", "year carry",  {15'h0, yc}, {15'h0, eyc});
    endtask

    task automatic run_to(input int d, input int m, input int y, input string tag);
        while (!(md == d && mm == m && my == y)) adv_main(1'b0, 1'b1, tag);
    endtask

    task automatic t_reset;
        chk(day_o == 8'h01,    "R10", "reset day",   {8'h0, day_o},   16'h0001);
        chk(month_o == 8'h01,  "R10", "reset month", {8'h0, month_o}, 16'h0001);
        chk(year_o == 16'h2000,"R10", "reset year",  year_o, 16'h2000);
        chk(!mc && !yc,        "R10", "reset carries", {14'h0, mc, yc}, 16'h0);
    endtask

    task automatic t_hold;
        repeat (3) @(negedge clk);
        chk(day_o == b2(md) && month_o == b2(mm) && year_o == b4(my), "R5",
            "idle hold", {8'h0, day_o}, {8'h0, b2(md)});
        chk(!mc && !yc, "R5", "idle carries", {14'h0, mc, yc}, 16'h0);
    endtask

    task automatic t_sources;
        adv_main(1'b0, 1'b1, "R5");
        adv_main(1'b1, 1'b0, "R5");
        adv_main(1'b1, 1'b1, "R5");
        chk(day_o == 8'h04, "R5", "both sources give one day", {8'h0, day_o}, 16'h0004);
    endtask

    task automatic t_digits;
        run_to(9, 1, 2000, "R2");
        chk(day_o == 8'h09, "R2", "units step", {8'h0, day_o}, 16'h0009);
        adv_main(1'b1, 1'b0, "R3");
        chk(day_o == 8'h10, "R3", "tens step", {8'h0, day_o}, 16'h0010);
        run_to(20, 1, 2000, "R3");
        chk(day_o == 8'h20, "R3", "19 to 20", {8'h0, day_o}, 16'h0020);
    endtask

    task automatic t_month_end;
        run_to(31, 1, 2000, "R6");
        chk(day_o == 8'h31, "R6", "January 31", {8'h0, day_o}, 16'h0031);
        adv_main(1'b0, 1'b1, "R4");
        chk(mc && day_o == 8'h01 && month_o == 8'h02, "R4", "wrap to Feb 01",
            {7'h0, mc, day_o}, 16'h0101);
        @(negedge clk);
        chk(!mc, "R4", "carry one cycle", {15'h0, mc}, 16'h0);
        run_to(30, 4, 2000, "R6");
        adv_main(1'b0, 1'b1, "R6");
        chk(month_o == 8'h05 && day_o == 8'h01, "R6", "April has 30",
            {month_o, day_o}, 16'h0501);
        run_to(31, 5, 2000, "R6");
        adv_main(1'b1, 1'b0, "R6");
        chk(month_o == 8'h06 && day_o == 8'h01, "R6", "May 31 to June 01",
            {month_o, day_o}, 16'h0601);
    endtask

    task automatic t_leap_and_year;
        run_to(1, 1, 2001, "R8");
        chk(year_o == 16'h2001 && month_o == 8'h01, "R8", "Dec wraps to Jan",
            year_o, 16'h2001);
        run_to(28, 2, 2001, "R7");
        adv_main(1'b0, 1'b1, "R7");
        chk(month_o == 8'h03 && day_o == 8'h01, "R7", "2001 Feb has 28",
            {month_o, day_o}, 16'h0301);
        run_to(28, 2, 2004, "R7");
        adv_main(1'b0, 1'b1, "R7");
        chk(month_o == 8'h02 && day_o == 8'h29, "R7", "2004 Feb 29",
            {month_o, day_o}, 16'h0229);
        run_to(1, 1, 2010, "R9");
        chk(year_o == 16'h2010, "R9", "2009 ripples to 2010", year_o, 16'h2010);
    endtask

    task automatic t_year_wrap;
        for (int i = 0; i < 730; i++) begin
            wd++;
            if (wd > mlen(wm, wy)) begin
                wd = 1; wm++;
                if (wm > 12) begin wm = 1; wy = (wy + 1) % 10000; end
            end
            @(negedge clk); adj_w = 1'b1;
            @(negedge clk); adj_w = 1'b0;
            chk(day_w == b2(wd) && month_w == b2(wm) && year_w == b4(wy), "R9",
                "wrap instance date", year_w, b4(wy));
        end
        chk(year_w == 16'h0000, "R9", "9999 to 0000", year_w, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hold();
        t_sources();
        t_digits();
        t_month_end();
        t_hold();
        t_leap_and_year();
        t_year_wrap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule